// File: doc/BRIEF.md
# Paged external memory bus controller

This block runs the external memory cycles of an 8-bit processor core with a 16-bit address space. The core asks for an instruction fetch, a data read or a data write. The controller then sequences the address latch enable, the three active-low strobes and two 8-bit bus ports. Each request is classified as a page hit or a page miss. A page hit happens when the upper address byte matches the upper byte of the previous external access. On a hit the cycle leaves out the high-byte address phase and the latch pulse, which shortens it.

A page-enable bit and a two-bit select field pick the cycle timing and the bus arrangement.

- **Select 0, 1 and 2.** Port A carries the address, with the high byte and then the low byte in time. Port B is a dedicated data bus.
- **Select 3.** Port B carries the low address byte. Port A carries the high byte first and then the data.
- **Page-enable clear.** The controller falls back to a fixed, conventional multiplexed cycle.

The core holds `req_valid` and the request fields until the controller answers. The controller answers with a one-clock `req_ready`, and `req_rdata` is valid in that same clock.

Top module: `pgbus_ctrl`

## Requirements
- R1: After reset, `ale` is 0, all strobes are 1, both output enables are 0 and `req_ready` is 0. The first access after reset is a page miss.
- R2: An access is a page hit only in two cases together. Its upper address byte equals that of the previous accepted access, and the page-enable and select settings are unchanged since that access. Anything else is a page miss.
- R3: A request is accepted on a clock edge. With page mode on and select 0, 1 or 2, the cycle then occupies L clocks, with L = 1, 2, 4 on a hit and 2, 4, 8 on a miss. `req_ready` is high for the clock right after those L clocks.
- R4: With select 0 to 2, a miss has two halves:
  - First half: `ale` is 1 and port A drives the high address byte.
  - Second half: port A drives the low byte and the strobe is low.
  - On a hit, `ale` stays 0 and port A drives the low byte with the strobe low for the whole cycle.
- R5: With select 3, a fetch drives the low address byte on port B for the whole cycle.
  - Miss: 2 clocks of `ale` with the high byte on port A, then 2 strobe clocks with port A released.
  - Hit: 2 strobe clocks only, with no `ale`.
- R6: With select 3, every data read or write takes 4 clocks: 2 clocks of `ale` and high byte, then 2 strobe clocks. This holds whether the access is a hit or a miss.
- R7: The strobe is chosen by request kind: kind 0 is a fetch and uses `psen_n`, kind 1 or 3 is a read and uses `rd_n`, and kind 2 is a write and uses `wr_n`. At most one strobe is low in any clock, and no strobe is low while `ale` is 1.
- R8: During a write strobe, both ports are driven, and the port that carries data drives `req_wdata`. During a fetch or read strobe, exactly one port is driven, and the data port is released.
- R9: For a fetch or read, the data port is sampled on the edge that ends the last strobe clock. The data port is port A for select 3 and port B otherwise. The sampled byte appears on `req_rdata` while `req_ready` is high. A write leaves `req_rdata` unchanged.
- R10: With page mode off, every access takes 4 clocks, with `req_ready` in the 5th. Port A carries the high address byte throughout.
  - Clock 0: `ale` is 1 and port B carries the low byte.
  - Clocks 1 and 2: the strobe is low, and for a write port B carries the write data.
  - Clock 3: all strobes are released.
- R11: Request fields are latched when the request is accepted, and later changes have no effect on the running cycle. No request is accepted while a cycle runs or while `req_ready` is high. `req_ready` lasts one clock, and during it the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page_en | input | 1 | Page mode enable |
| cfg_page_sel | input | 2 | Page timing / bus arrangement select |
| req_valid | input | 1 | Core request pending |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Fetched or read byte |
| pa_o | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A drive enable |
| pa_i | input | 8 | Port A input value |
| pb_o | output | 8 | Port B output value |
| pb_oe | output | 1 | Port B drive enable |
| pb_i | input | 8 | Port B input value |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The assertions check the bus rules on every cycle in every mode:
- one strobe at a time, never overlapping `ale`;
- both ports driven during a write strobe and exactly one during a fetch or read strobe;
- a single-clock ready with a quiet bus during it.

Only the bench's scenarios can show the rest. That covers hit/miss classification, including loss of the page after a configuration change or reset, and the exact clock-by-clock shape of each cycle length. It also covers which byte appears on which port and the sampled read data. The bench's reference model derives these from the address history it keeps itself.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;

  localparam int CNT_W = 4;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  // Shape of one external cycle: total clocks, clocks of address phase,
  // index of the last strobe clock, and the bus arrangement.
  typedef struct packed {
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] aph;
    logic [CNT_W-1:0] slast;
    logic             hi_mux;
    logic             nonpage;
  } cyc_plan_t;

  function automatic cyc_plan_t plan_cycle(input logic en, input logic [1:0] sel,
                                           input logic [1:0] kind, input logic hit);
    cyc_plan_t        p;
    logic [CNT_W-1:0] h;
    p = '0;
    h = CNT_W'(1) << sel;
    if (!en) begin
      p.len     = CNT_W'(4);
      p.aph     = CNT_W'(1);
      p.slast   = CNT_W'(2);
      p.nonpage = 1'b1;
    end else if (sel == 2'b11) begin
      p.hi_mux = 1'b1;
      if (kind == KIND_FETCH && hit) begin
        p.len   = CNT_W'(2);
        p.aph   = '0;
        p.slast = CNT_W'(1);
      end else begin
        p.len   = CNT_W'(4);
        p.aph   = CNT_W'(2);
        p.slast = CNT_W'(3);
      end
    end else if (hit) begin
      p.len   = h;
      p.aph   = '0;
      p.slast = h - CNT_W'(1);
    end else begin
      p.len   = h << 1;
      p.aph   = h;
      p.slast = (h << 1) - CNT_W'(1);
    end
    return p;
  endfunction

endpackage

// File: rtl/pgbus_pagetrack.sv
module pgbus_pagetrack #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic [1:0]      cfg_sel,
  input  logic [HI_W-1:0] hi,
  input  logic            upd,
  output logic            hit
);
  logic [HI_W-1:0] last_hi;
  logic [2:0]      last_cfg;
  logic            known;

  assign hit = known && (last_hi == hi) && (last_cfg == {cfg_en, cfg_sel});

  always_ff @(posedge clk) begin
    if (rst) begin
      known    <= 1'b0;
      last_hi  <= '0;
      last_cfg <= '0;
    end else if (upd) begin
      known    <= 1'b1;
      last_hi  <= hi;
      last_cfg <= {cfg_en, cfg_sel};
    end
  end
endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic [CNT_W-1:0] k,
  output logic             nxt_act,
  output logic [CNT_W-1:0] nxt_k,
  output logic             done
);
  logic at_end;

  assign at_end  = busy && (k == len - CNT_W'(1));
  assign nxt_act = start || (busy && !at_end);
  assign nxt_k   = start ? '0 : k + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      k    <= '0;
      done <= 1'b0;
    end else begin
      done <= at_end;
      if (start) begin
        busy <= 1'b1;
        k    <= '0;
      end else if (at_end) begin
        busy <= 1'b0;
      end else if (busy) begin
        k <= k + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pgbus_pindrive.sv
module pgbus_pindrive
  import pgbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act,
  input  logic [CNT_W-1:0]    k,
  input  cyc_plan_t           plan,
  input  logic [1:0]          kind,
  input  logic [2*DATA_W-1:0] addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   pa_o,
  output logic                pa_oe,
  output logic [DATA_W-1:0]   pb_o,
  output logic                pb_oe,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);
  logic [DATA_W-1:0] hi_b, lo_b, n_pa, n_pb;
  logic n_pa_oe, n_pb_oe, n_ale, n_ps, n_rd, n_wr;
  logic in_addr, in_strb, is_wr;

  assign hi_b    = addr[2*DATA_W-1:DATA_W];
  assign lo_b    = addr[DATA_W-1:0];
  assign in_addr = k < plan.aph;
  assign in_strb = (k >= plan.aph) && (k <= plan.slast);
  assign is_wr   = (kind == KIND_WRITE);

  always_comb begin
    n_ale   = 1'b0;
    n_ps    = 1'b1;
    n_rd    = 1'b1;
    n_wr    = 1'b1;
    n_pa    = '0;
    n_pa_oe = 1'b0;
    n_pb    = '0;
    n_pb_oe = 1'b0;
    if (act) begin
      n_ale = in_addr;
      if (in_strb) begin
        n_ps = !(kind == KIND_FETCH);
        n_wr = !is_wr;
        n_rd = (kind == KIND_FETCH) || is_wr;
      end
      if (plan.nonpage) begin
        n_pa    = hi_b;
        n_pa_oe = 1'b1;
        if (in_addr) begin
          n_pb    = lo_b;
          n_pb_oe = 1'b1;
        end else if (in_strb && is_wr) begin
          n_pb    = wdata;
          n_pb_oe = 1'b1;
        end
      end else if (plan.hi_mux) begin
        n_pb    = lo_b;
        n_pb_oe = 1'b1;
        if (in_addr) begin
          n_pa    = hi_b;
          n_pa_oe = 1'b1;
        end else if (is_wr) begin
          n_pa    = wdata;
          n_pa_oe = 1'b1;
        end
      end else begin
        n_pa_oe = 1'b1;
        n_pa    = in_addr ? hi_b : lo_b;
        if (is_wr && !in_addr) begin
          n_pb    = wdata;
          n_pb_oe = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      pa_o   <= '0;
      pa_oe  <= 1'b0;
      pb_o   <= '0;
      pb_oe  <= 1'b0;
    end else begin
      ale    <= n_ale;
      psen_n <= n_ps;
      rd_n   <= n_rd;
      wr_n   <= n_wr;
      pa_o   <= n_pa;
      pa_oe  <= n_pa_oe;
      pb_o   <= n_pb;
      pb_oe  <= n_pb_oe;
    end
  end
endmodule

// File: rtl/pgbus_ctrl.sv
module pgbus_ctrl
  import pgbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_page_en,
  input  logic [1:0]          cfg_page_sel,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic [DATA_W-1:0]   req_rdata,
  output logic [DATA_W-1:0]   pa_o,
  output logic                pa_oe,
  input  logic [DATA_W-1:0]   pa_i,
  output logic [DATA_W-1:0]   pb_o,
  output logic                pb_oe,
  input  logic [DATA_W-1:0]   pb_i,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);
  localparam int ADDR_W = 2 * DATA_W;

  logic             busy, nxt_act, hit, accept, capture;
  logic [CNT_W-1:0] k, nxt_k;
  cyc_plan_t        plan_new, plan_q, plan_n;
  logic [1:0]       kind_q, kind_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n, rdata_q;

  assign accept   = req_valid && !busy && !req_ready;
  assign plan_new = plan_cycle(cfg_page_en, cfg_page_sel, req_kind, hit);
  assign plan_n   = accept ? plan_new  : plan_q;
  assign kind_n   = accept ? req_kind  : kind_q;
  assign addr_n   = accept ? req_addr  : addr_q;
  assign wdata_n  = accept ? req_wdata : wdata_q;
  assign capture  = busy && (k == plan_q.slast) && (kind_q != KIND_WRITE);

  pgbus_pagetrack #(.HI_W(DATA_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_page_en),
    .cfg_sel (cfg_page_sel),
    .hi      (req_addr[ADDR_W-1:DATA_W]),
    .upd     (accept),
    .hit     (hit)
  );

  pgbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .len     (plan_q.len),
    .busy    (busy),
    .k       (k),
    .nxt_act (nxt_act),
    .nxt_k   (nxt_k),
    .done    (req_ready)
  );

  pgbus_pindrive #(.DATA_W(DATA_W)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .act    (nxt_act),
    .k      (nxt_k),
    .plan   (plan_n),
    .kind   (kind_n),
    .addr   (addr_n),
    .wdata  (wdata_n),
    .pa_o   (pa_o),
    .pa_oe  (pa_oe),
    .pb_o   (pb_o),
    .pb_oe  (pb_oe),
    .ale    (ale),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      plan_q  <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        plan_q  <= plan_new;
        kind_q  <= req_kind;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= plan_q.hi_mux ? pa_i : pb_i;
    end
  end

  assign req_rdata = rdata_q;
endmodule

// File: rtl/pgbus_ctrl_chk.sv
module pgbus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic pa_oe,
  input logic pb_oe,
  input logic req_ready
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({psen_n, rd_n, wr_n}) >= 2); // R7
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n)); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (pa_oe && pb_oe)); // R8
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> ($countones({pa_oe, pb_oe}) == 1)); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R11
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ale && psen_n && rd_n && wr_n && !pa_oe && !pb_oe)); // R11
endmodule

bind pgbus_ctrl pgbus_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .pa_oe     (pa_oe),
  .pb_oe     (pb_oe),
  .req_ready (req_ready)
);

// File: tb/pgbus_ctrl_tb.sv
module pgbus_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst = 1'b1;
  logic page_en = 1'b0;
  logic [1:0] page_sel = 2'd0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, pa_i = '0, pb_i = '0;
  logic req_ready, pa_oe, pb_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] req_rdata, pa_o, pb_o;

  pgbus_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_page_en(page_en), .cfg_page_sel(page_sel),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .pa_o(pa_o), .pa_oe(pa_oe), .pa_i(pa_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .pb_i(pb_i), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int n_chk = 0, n_err = 0;
  bit have_last = 0;
  logic [7:0] last_hi = '0, exp_rd = '0;
  logic [2:0] last_cfg = '0;

  localparam logic [31:0] IDLE_VEC = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 24'h0};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pins_now();
    return {ale, psen_n, rd_n, wr_n, pa_oe, pb_oe, 2'b00,
            pa_oe ? pa_o : 8'h00, pb_oe ? pb_o : 8'h00, 8'h00};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    have_last = 0;
    exp_rd = '0;
    @(negedge clk);
    chk(pins_now() == IDLE_VEC, "R1 idle pins", pins_now(), IDLE_VEC);
    chk(req_ready == 1'b0, "R1 ready low", 32'(req_ready), 32'd0);
    chk(req_rdata == 8'h00, "R1 rdata", 32'(req_rdata), 32'd0);
  endtask

  // Reference model: derives every clock of the cycle from the requirements.
  task automatic do_access(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] wd);
    int L, A, SE, h;
    bit hit, mux, np, strb, wr;
    logic [7:0] hi, lo, pav, pbv, ea, eb;
    logic ea_oe, eb_oe, e_ale;
    logic [31:0] ev;
    string tag, ttag;
    hi = addr[15:8];
    lo = addr[7:0];
    wr = (kind == 2'd2);
    hit = have_last && (last_hi == hi) && (last_cfg == {page_en, page_sel});
    have_last = 1;
    last_hi = hi;
    last_cfg = {page_en, page_sel};
    np  = !page_en;
    mux = page_en && (page_sel == 2'd3);
    if (np) begin
      L = 4; A = 1; SE = 2; tag = "R10"; ttag = "R10";
    end else if (mux) begin
      if (kind == 2'd0) begin
        tag = "R5"; L = hit ? 2 : 4; A = hit ? 0 : 2;
      end else begin
        tag = "R6"; L = 4; A = 2;
      end
      ttag = tag; SE = L - 1;
    end else begin
      h = 1 << page_sel;
      L = hit ? h : 2 * h; A = hit ? 0 : h; SE = L - 1;
      tag = "R4"; ttag = "R3";
    end
    pav = lo ^ hi ^ 8'h3C;
    pbv = pav ^ 8'hA5;
    if (!wr) exp_rd = mux ? pav : pbv;

    @(negedge clk);
    pa_i = pav; pb_i = pbv;
    req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1;

    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_addr = ~addr;   // R11: late changes must not reach the bus
        req_wdata = ~wd;
      end
      e_ale = (k < A);
      strb  = (k >= A) && (k <= SE);
      if (np) begin
        ea_oe = 1; ea = hi;
        eb_oe = (k < A) || (strb && wr); eb = (k < A) ? lo : wd;
      end else if (mux) begin
        eb_oe = 1; eb = lo;
        ea_oe = (k < A) || wr; ea = (k < A) ? hi : wd;
      end else begin
        ea_oe = 1; ea = (k < A) ? hi : lo;
        eb_oe = wr && (k >= A); eb = wd;
      end
      // pin vector covers R4 R5 R6 R8 R10 and the strobe choice of R7
      ev = {e_ale, !(strb && kind == 2'd0), !(strb && (kind == 2'd1 || kind == 2'd3)),
            !(strb && wr), ea_oe, eb_oe, 2'b00, ea_oe ? ea : 8'h00, eb_oe ? eb : 8'h00, 8'h00};
      chk(pins_now() == ev, tag, pins_now(), ev);
      if (k == 0 && !np && !(mux && kind != 2'd0))
        chk(ale == !hit, "R2 hit/miss", 32'(ale), 32'(!hit));
      chk(req_ready == 1'b0, "R11 ready during cycle", 32'(req_ready), 32'd0);
      chk($countones({psen_n, rd_n, wr_n}) >= 2, "R7 one strobe", {29'd0, psen_n, rd_n, wr_n}, 32'd0);
    end

    @(negedge clk);
    chk(req_ready == 1'b1, ttag, 32'(req_ready), 32'd1);
    chk(pins_now() == IDLE_VEC, "R11 quiet in ready clock", pins_now(), IDLE_VEC);
    chk(req_rdata == exp_rd, "R9 read data", 32'(req_rdata), 32'(exp_rd));
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();                       // R1

    page_en = 1'b0;                   // R10 nonpage
    do_access(2'd0, 16'h1234, 8'h00);
    do_access(2'd1, 16'h1235, 8'h00);
    do_access(2'd2, 16'h8000, 8'h5A);

    for (int s = 0; s < 3; s++) begin // R3 R4 R2
      page_en = 1'b1;
      page_sel = 2'(s);
      do_access(2'd0, 16'h1234, 8'h00);
      do_access(2'd0, 16'h1240, 8'h00);
      do_access(2'd1, 16'h12FF, 8'h00);
      do_access(2'd2, 16'h1300, 8'hC3);
      do_access(2'd2, 16'h1301, 8'h3C);
      do_access(2'd3, 16'h1302, 8'h00);
      do_access(2'd0, 16'h1234, 8'h00);
    end

    page_sel = 2'd3;                  // R5 R6
    do_access(2'd0, 16'h4000, 8'h00);
    do_access(2'd0, 16'h4001, 8'h00);
    do_access(2'd1, 16'h4002, 8'h00);
    do_access(2'd2, 16'h4003, 8'h96);
    do_access(2'd0, 16'h4004, 8'h00);
    do_access(2'd1, 16'h5000, 8'h00);
    do_access(2'd0, 16'h5001, 8'h00);

    page_sel = 2'd1;                  // R2 configuration change drops the page
    do_access(2'd0, 16'h7700, 8'h00);
    page_sel = 2'd0;
    do_access(2'd0, 16'h7701, 8'h00);
    do_access(2'd0, 16'h7702, 8'h00);

    do_reset();                       // R1 first access after reset misses
    page_en = 1'b1;
    page_sel = 2'd0;
    do_access(2'd0, 16'h7703, 8'h00);
    do_access(2'd1, 16'h7704, 8'h00);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule